// File: doc/BRIEF.md
# Power-Up SPI Configuration Sequencer

At power-up this block programs up to three external SPI devices, one after another. Typical devices are a data converter pair and a clock synthesizer. Each device has its own configuration ROM, held outside the block. The sequencer reads that ROM one word at a time and sends each word as a 24-bit write-only SPI frame to the device's own chip select. It then waits for the frame to finish before it fetches the next word. A word of all ones ends the current device's list, so each device may have a different number of words and no length needs to be stored.

After the last device is finished, the block stops issuing reads and frames. It holds a sticky completion flag and emits a single-cycle start pulse, which downstream link, transport and pattern logic use as permission to begin their own initialization. A device that is not fitted is described by a ROM whose first word is the terminator. If a ROM has no terminator, the sequencer stops that device at its highest address and raises a sticky error flag.

Programming begins by itself on the first clock after reset is released. Each ROM word holds an instruction byte in bits [23:16] (zero for a write), a register address in bits [15:8] and a data byte in bits [7:0]. The sequencer transmits all 24 bits unchanged.

Top module: `cfg_spi_sequencer`

## Requirements
- R1: While `rst_n` is low, every bit of `spi_cs_n` is high, `spi_sclk` is low, `config_done`, `init_start` and `seq_error` are low, and `busy` is high. A reset asserted in the middle of a frame abandons that frame at once.
- R2: Each ROM word other than the terminator goes out as one frame. During the frame one `spi_cs_n` bit is held low for exactly 24 rising edges of `spi_sclk`. `spi_mosi` carries the word most significant bit first, changes only while `spi_sclk` is low, and is sampled on the rising edge (SPI mode 0).
- R3: The terminator 24'hFFFFFF is never transmitted; it ends the current device's list. Any other value, including 24'hFFFFFE, is transmitted.
- R4: Devices are handled in index order 0, 1, 2. Words fetched with `rom_dev` = i go only to chip select bit `spi_cs_n[i]`.
- R5: A device whose ROM holds the terminator at address 0 receives no frames.
- R6: A ROM read is one cycle with `rom_rd` high. `rom_data` is taken on the following cycle. Addresses start at 0 for each device and rise by one per word. Reads happen only while every chip select is high.
- R7: After the last frame of the last device, `busy` falls and `config_done` rises and stays high until reset. `init_start` is high for exactly one cycle, the first cycle of `config_done`. After that no further reads or frames occur.
- R8: If the word at the last address (ROM_DEPTH-1) is not the terminator, it is transmitted, that device's list ends, and `seq_error` rises and stays high until reset. The remaining devices are still programmed.
- R9: `spi_sclk` is low whenever no chip select is active. Each of its half-periods lasts HALF_DIV clock cycles, and the first rising edge comes HALF_DIV cycles after the chip select falls.
- R10: At most one bit of `spi_cs_n` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_rd | output | 1 | ROM read strobe, one cycle per word |
| rom_dev | output | DEV_W (2) | Device ROM select |
| rom_addr | output | ADDR_W (3) | Word address within the selected ROM |
| rom_data | input | WORD_W (24) | ROM word, valid the cycle after `rom_rd` |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_mosi | output | 1 | SPI serial data out |
| spi_cs_n | output | NUM_DEV (3) | Active-low chip select, one per device |
| busy | output | 1 | High while programming is in progress |
| config_done | output | 1 | Sticky, high once all devices are finished |
| init_start | output | 1 | One-cycle pulse releasing downstream initialization |
| seq_error | output | 1 | Sticky, a ROM ran out of addresses without a terminator |

## Verification
The bound checker watches, on every cycle, the properties that depend only on signal relations. These are chip-select exclusivity, the idle-low clock, data stability while the clock is high, reads only between frames, the stickiness of the done and error flags, the single-cycle start pulse and the complementary relation of busy and done. Only the bench scenarios can show that:
- the frames carry exactly the ROM words, in order, to the right device;
- the terminator is withheld while a near-terminator value is sent;
- an unused device stays silent;
- the half-period length and read addresses are correct;
- a missing terminator at the top address sends that word and raises the error.

// File: rtl/cfgseq_pkg.sv
// Shared definitions for the SPI configuration sequencer.
// Assumes: the sequencer states listed here are the only ones the walker uses.
package cfgseq_pkg;

    localparam int DEF_WORD_W    = 24;
    localparam int DEF_ROM_DEPTH = 8;
    localparam int DEF_NUM_DEV   = 3;
    localparam int DEF_HALF_DIV  = 2;

    // Walker phases: fetch a word, examine it, wait for its frame, finished.
    typedef enum logic [1:0] {
        SQ_FETCH   = 2'd0,
        SQ_EXAMINE = 2'd1,
        SQ_SHIFT   = 2'd2,
        SQ_FINISH  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/cfg_spi_shifter.sv
// SPI mode-0 write-only shift engine.
// On a launch pulse (ignored while busy) it captures a word and shifts it MSB
// first. SCLK idles low and each SCLK half-period lasts HALF_DIV clocks.
// MOSI changes only on falling SCLK. After the last falling edge the frame
// ends and a one-cycle finished pulse follows on the next cycle.
// Assumes HALF_DIV >= 1 and WORD_W >= 2.
module cfg_spi_shifter #(
    parameter int WORD_W   = 24,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              mosi,
    output logic              active,
    output logic              finished
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic              sclk_q;
    logic              active_q;
    logic              fin_q;

    logic half_end;
    logic last_bit;

    assign half_end = (div_q == CNT_W'(HALF_DIV - 1));
    assign last_bit = (bit_q == BIT_W'(WORD_W - 1));

    // Frame control: load, divide, toggle SCLK, shift on falling edges, end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            div_q    <= '0;
            bit_q    <= '0;
            sclk_q   <= 1'b0;
            active_q <= 1'b0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!active_q) begin
                if (launch) begin
                    shreg_q  <= word;
                    active_q <= 1'b1;
                    sclk_q   <= 1'b0;
                    div_q    <= '0;
                    bit_q    <= '0;
                end
            end else if (half_end) begin
                div_q  <= '0;
                sclk_q <= ~sclk_q;
                if (sclk_q) begin
                    if (last_bit) begin
                        active_q <= 1'b0;
                        fin_q    <= 1'b1;
                    end else begin
                        shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                        bit_q   <= bit_q + 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sclk     = sclk_q;
    assign mosi     = active_q & shreg_q[WORD_W-1];
    assign active   = active_q;
    assign finished = fin_q;

endmodule

// File: rtl/cfg_cs_decode.sv
// Chip-select decoder: drives low the select of the current device while a
// frame is active; every other select stays high.
// Assumes the device index changes only when no frame is active.
module cfg_cs_decode #(
    parameter int NUM_DEV = 3,
    parameter int DEV_W   = 2
) (
    input  logic [DEV_W-1:0]   dev_sel,
    input  logic               frame_active,
    output logic [NUM_DEV-1:0] cs_n
);

    // One select line per device, generated from the index compare.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
        assign cs_n[g] = ~(frame_active && (dev_sel == DEV_W'(g)));
    end

endmodule

// File: rtl/cfg_rom_walker.sv
// ROM walking state machine.
// For each device in turn it reads words from address 0 upward. It waits one
// cycle of ROM latency, then launches a frame for each word that is not the
// terminator and waits for that frame to finish. It moves to the next device
// on the terminator, or after the word at the top address (setting a sticky
// error). After the last device it sets a sticky done flag and a one-cycle
// start pulse.
// Assumes ROM_DEPTH >= 2 and NUM_DEV >= 2.
module cfg_rom_walker
    import cfgseq_pkg::*;
#(
    parameter int NUM_DEV   = 3,
    parameter int ROM_DEPTH = 8,
    parameter int WORD_W    = 24,
    parameter int DEV_W     = 2,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rom_rd,
    output logic [DEV_W-1:0]  rom_dev,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    output logic              launch,
    output logic [WORD_W-1:0] word_out,
    input  logic              spi_finished,
    output logic              busy,
    output logic              config_done,
    output logic              init_start,
    output logic              seq_error
);

    seq_state_e        state_q;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              init_q;
    logic              err_q;

    logic is_term;
    logic last_dev;
    logic last_addr;
    logic next_dev;
    logic overrun;

    // Decode of the returned word and of the position counters.
    always_comb begin
        is_term   = &rom_data;
        last_dev  = (dev_q == DEV_W'(NUM_DEV - 1));
        last_addr = (addr_q == ADDR_W'(ROM_DEPTH - 1));
        overrun   = (state_q == SQ_SHIFT) && spi_finished && last_addr;
        next_dev  = ((state_q == SQ_EXAMINE) && is_term) || overrun;
    end

    // Sequencing of fetch, examine, shift and device advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_FETCH;
            dev_q   <= '0;
            addr_q  <= '0;
            done_q  <= 1'b0;
            init_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            init_q <= 1'b0;
            if (overrun) begin
                err_q <= 1'b1;
            end
            if (next_dev) begin
                if (last_dev) begin
                    state_q <= SQ_FINISH;
                    done_q  <= 1'b1;
                    init_q  <= 1'b1;
                end else begin
                    state_q <= SQ_FETCH;
                    dev_q   <= dev_q + 1'b1;
                    addr_q  <= '0;
                end
            end else begin
                case (state_q)
                    SQ_FETCH:   state_q <= SQ_EXAMINE;
                    SQ_EXAMINE: state_q <= SQ_SHIFT;
                    SQ_SHIFT: begin
                        if (spi_finished) begin
                            state_q <= SQ_FETCH;
                            addr_q  <= addr_q + 1'b1;
                        end
                    end
                    default:    state_q <= SQ_FINISH;
                endcase
            end
        end
    end

    assign rom_rd      = (state_q == SQ_FETCH);
    assign rom_dev     = dev_q;
    assign rom_addr    = addr_q;
    assign launch      = (state_q == SQ_EXAMINE) && !is_term;
    assign word_out    = rom_data;
    assign busy        = (state_q != SQ_FINISH);
    assign config_done = done_q;
    assign init_start  = init_q;
    assign seq_error   = err_q;

endmodule

// File: rtl/cfg_spi_sequencer.sv
// Top level of the power-up SPI configuration sequencer.
// It ties the ROM walker, the mode-0 shift engine and the chip-select decoder
// together. The ROMs are external and have one cycle of read latency.
// Programming starts by itself once reset is released.
module cfg_spi_sequencer #(
    parameter int NUM_DEV   = cfgseq_pkg::DEF_NUM_DEV,
    parameter int ROM_DEPTH = cfgseq_pkg::DEF_ROM_DEPTH,
    parameter int WORD_W    = cfgseq_pkg::DEF_WORD_W,
    parameter int HALF_DIV  = cfgseq_pkg::DEF_HALF_DIV,
    localparam int DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int ADDR_W   = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               rom_rd,
    output logic [DEV_W-1:0]   rom_dev,
    output logic [ADDR_W-1:0]  rom_addr,
    input  logic [WORD_W-1:0]  rom_data,
    output logic               spi_sclk,
    output logic               spi_mosi,
    output logic [NUM_DEV-1:0] spi_cs_n,
    output logic               busy,
    output logic               config_done,
    output logic               init_start,
    output logic               seq_error
);

    logic              launch;
    logic [WORD_W-1:0] word;
    logic              frame_active;
    logic              frame_fin;

    cfg_rom_walker #(
        .NUM_DEV   (NUM_DEV),
        .ROM_DEPTH (ROM_DEPTH),
        .WORD_W    (WORD_W),
        .DEV_W     (DEV_W),
        .ADDR_W    (ADDR_W)
    ) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .rom_rd       (rom_rd),
        .rom_dev      (rom_dev),
        .rom_addr     (rom_addr),
        .rom_data     (rom_data),
        .launch       (launch),
        .word_out     (word),
        .spi_finished (frame_fin),
        .busy         (busy),
        .config_done  (config_done),
        .init_start   (init_start),
        .seq_error    (seq_error)
    );

    cfg_spi_shifter #(
        .WORD_W   (WORD_W),
        .HALF_DIV (HALF_DIV)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .word     (word),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .active   (frame_active),
        .finished (frame_fin)
    );

    cfg_cs_decode #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W)
    ) u_cs (
        .dev_sel      (rom_dev),
        .frame_active (frame_active),
        .cs_n         (spi_cs_n)
    );

endmodule

// File: rtl/cfg_spi_sequencer_chk.sv
// Protocol checker for cfg_spi_sequencer, attached by bind below.
// It observes top-level ports only and drives nothing.
module cfg_spi_sequencer_chk #(
    parameter int NUM_DEV = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rom_rd,
    input logic               spi_sclk,
    input logic               spi_mosi,
    input logic [NUM_DEV-1:0] spi_cs_n,
    input logic               busy,
    input logic               config_done,
    input logic               init_start,
    input logic               seq_error
);

    p_cs_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&spi_cs_n) |-> !spi_sclk);

    p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    p_read_between_frames_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> (busy && (&spi_cs_n)));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        config_done |=> config_done);

    p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> !init_start);

    p_start_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> (config_done && $rose(config_done)));

    p_busy_vs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy != config_done);

    p_error_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |=> seq_error);

endmodule

bind cfg_spi_sequencer cfg_spi_sequencer_chk #(
    .NUM_DEV (NUM_DEV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rom_rd      (rom_rd),
    .spi_sclk    (spi_sclk),
    .spi_mosi    (spi_mosi),
    .spi_cs_n    (spi_cs_n),
    .busy        (busy),
    .config_done (config_done),
    .init_start  (init_start),
    .seq_error   (seq_error)
);

// File: tb/tb_cfg_spi_sequencer.sv
module tb_cfg_spi_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 3;
    localparam int DEPTH      = 8;
    localparam int WW         = 24;
    localparam int HALF       = 2;
    localparam int NSC        = 3;
    localparam logic [23:0] TERM = 24'hFFFFFF;
    localparam logic [23:0] PADW = 24'h0000AA;

    // Stimulus table: ROM images per scenario. Expected frames are derived
    // from them by the rules in the requirements.
    localparam logic [23:0] SCEN [NSC][NDEV][DEPTH] = '{
        '{ '{24'h005F15, 24'h005E44, 24'h0064C0, 24'h006E03,
             24'h00700F, 24'h000D04, 24'h005F14, TERM},
           '{24'h001234, 24'h00ABCD, TERM, PADW, PADW, PADW, PADW, PADW},
           '{24'h000180, TERM, PADW, PADW, PADW, PADW, PADW, PADW} },
        '{ '{TERM, PADW, PADW, PADW, PADW, PADW, PADW, PADW},
           '{24'h004001, 24'h800001, 24'h0042FE, TERM, PADW, PADW, PADW, PADW},
           '{TERM, PADW, PADW, PADW, PADW, PADW, PADW, PADW} },
        '{ '{24'h000111, 24'hFFFFFE, 24'h000333, 24'h000444,
             24'h000555, 24'h000666, 24'h000777, 24'h7FFFFF},
           '{TERM, PADW, PADW, PADW, PADW, PADW, PADW, PADW},
           '{24'h00C3A5, TERM, PADW, PADW, PADW, PADW, PADW, PADW} }
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rom_rd;
    logic [1:0]       rom_dev;
    logic [2:0]       rom_addr;
    logic [WW-1:0]    rom_data;
    logic             spi_sclk;
    logic             spi_mosi;
    logic [NDEV-1:0]  spi_cs_n;
    logic             busy;
    logic             config_done;
    logic             init_start;
    logic             seq_error;

    cfg_spi_sequencer #(
        .NUM_DEV(NDEV), .ROM_DEPTH(DEPTH), .WORD_W(WW), .HALF_DIV(HALF)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rom_rd(rom_rd), .rom_dev(rom_dev),
        .rom_addr(rom_addr), .rom_data(rom_data), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .busy(busy),
        .config_done(config_done), .init_start(init_start),
        .seq_error(seq_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // ROM model with one cycle of read latency
    logic [23:0] rom_img [NDEV][DEPTH];
    always @(posedge clk) begin
        if (rom_rd) rom_data <= rom_img[rom_dev][rom_addr];
    end

    // Monitor state
    logic [23:0] fr_word [64];
    int          fr_dev  [64];
    int          fr_bits [64];
    int          nfr, per_err, multi_err, addr_err, init_cnt, fr_at_init;
    int          reads_total;
    bit          done_at_init;
    logic [NDEV-1:0] prev_cs_low;
    logic        prev_sclk;
    logic [23:0] cur_word;
    int          cur_bits, cur_dev, since;
    int          last_rd_dev, last_rd_addr;

    task automatic clear_monitor();
        nfr = 0; per_err = 0; multi_err = 0; addr_err = 0; init_cnt = 0;
        fr_at_init = -1; done_at_init = 0; reads_total = 0;
        last_rd_dev = -1; last_rd_addr = -1;
    endtask

    always @(negedge clk) begin
        logic [NDEV-1:0] cs_low;
        cs_low = ~spi_cs_n;
        if (!rst_n) begin
            prev_cs_low = '0;
            prev_sclk   = 1'b0;
        end else begin
            if ($countones(cs_low) > 1) multi_err++;
            if (prev_cs_low == '0 && cs_low != '0) begin
                cur_word = '0; cur_bits = 0; since = 1;
                for (int i = 0; i < NDEV; i++) if (cs_low[i]) cur_dev = i;
            end else if (cs_low != '0) begin
                if (spi_sclk != prev_sclk) begin
                    if (since != HALF) per_err++;
                    since = 1;
                end else begin
                    since++;
                end
                if (!prev_sclk && spi_sclk) begin
                    cur_word = {cur_word[22:0], spi_mosi};
                    cur_bits++;
                end
            end else if (prev_cs_low != '0) begin
                if (nfr < 64) begin
                    fr_word[nfr] = cur_word; fr_dev[nfr] = cur_dev; fr_bits[nfr] = cur_bits;
                end
                nfr++;
            end
            if (cs_low == '0 && spi_sclk) per_err++;
            if (rom_rd) begin
                reads_total++;
                if (int'(rom_dev) != last_rd_dev) begin
                    if (rom_addr != 0 || int'(rom_dev) < last_rd_dev) addr_err++;
                end else if (int'(rom_addr) != last_rd_addr + 1) begin
                    addr_err++;
                end
                last_rd_dev = int'(rom_dev); last_rd_addr = int'(rom_addr);
            end
            if (init_start) begin
                init_cnt++; fr_at_init = nfr; done_at_init = config_done;
            end
            prev_cs_low = cs_low;
            prev_sclk   = spi_sclk;
        end
    end

    // Expected frame list
    logic [23:0] ex_word [64];
    int          ex_dev  [64];
    int          nex;
    bit          ex_err;

    task automatic build_expected();
        nex = 0; ex_err = 0;
        for (int d = 0; d < NDEV; d++) begin
            for (int a = 0; a < DEPTH; a++) begin
                if (rom_img[d][a] == TERM) break;
                ex_word[nex] = rom_img[d][a]; ex_dev[nex] = d; nex++;
                if (a == DEPTH - 1) ex_err = 1;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(spi_cs_n == '1, "R1", "cs_n in reset", spi_cs_n, 3'b111);
        check(!spi_sclk && !config_done && !init_start && !seq_error && busy,
              "R1", "sclk/done/start/err/busy in reset",
              {spi_sclk, config_done, init_start, seq_error, busy}, 5'b00001);
        clear_monitor();
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!config_done && t < 20000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic score(input int s);
        int dev0;
        check(nfr == nex, "R2", $sformatf("sc%0d frame count", s), nfr, nex);
        for (int k = 0; k < nex && k < nfr; k++) begin
            check(fr_word[k] == ex_word[k], "R3", $sformatf("sc%0d frame %0d word", s, k), fr_word[k], ex_word[k]);
            check(fr_dev[k] == ex_dev[k], "R4", $sformatf("sc%0d frame %0d device", s, k), fr_dev[k], ex_dev[k]);
            check(fr_bits[k] == 24, "R2", $sformatf("sc%0d frame %0d clocks", s, k), fr_bits[k], 24);
        end
        check(per_err == 0, "R9", "sclk half-period / idle level", per_err, 0);
        check(multi_err == 0, "R10", "multiple selects low", multi_err, 0);
        check(addr_err == 0, "R6", "ROM address order", addr_err, 0);
        check(init_cnt == 1 && done_at_init && fr_at_init == nex, "R7",
              "single start pulse after last frame", {init_cnt, fr_at_init}, {32'd1, nex});
        check(config_done && !busy, "R7", "done high busy low", {config_done, busy}, 2'b10);
        check(seq_error == ex_err, "R8", "error flag", seq_error, ex_err);
        dev0 = 0;
        for (int d = 0; d < NDEV; d++) begin
            if (rom_img[d][0] == TERM) begin
                dev0 = 0;
                for (int k = 0; k < nfr && k < 64; k++) if (fr_dev[k] == d) dev0++;
                check(dev0 == 0, "R5", $sformatf("unused device %0d silent", d), dev0, 0);
            end
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int rd_before, fr_before;
        // Table walk
        for (int s = 0; s < NSC; s++) begin
            rom_img = SCEN[s];
            build_expected();
            do_reset();
            wait_done();
            score(s);
        end

        // Directed: reset in the middle of a frame (R1)
        rom_img = SCEN[0];
        build_expected();
        do_reset();
        while (spi_cs_n == '1) @(negedge clk);
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(spi_cs_n == '1 && !spi_sclk, "R1", "frame abandoned on reset", {spi_cs_n, spi_sclk}, 4'b1110);
        check(busy && !config_done && !seq_error, "R1", "flags on mid-frame reset",
              {busy, config_done, seq_error}, 3'b100);

        // Directed: rerun after reset, then idle stays idle (R7)
        do_reset();
        wait_done();
        score(9);
        rd_before = reads_total; fr_before = nfr;
        repeat (300) @(negedge clk);
        check(config_done && init_cnt == 1, "R7", "done sticky, no second pulse",
              {config_done, init_cnt}, {1'b1, 32'd1});
        check(reads_total == rd_before && nfr == fr_before, "R7", "no activity after done",
              reads_total - rd_before + nfr - fr_before, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule